// File: doc/BRIEF.md
# Switching-Cycle Oscillator with External Sync Selection

This block produces the start-of-cycle strobe for a switching regulator controller. It runs from a fast system clock and divides that clock down to one of two nominal switching rates. A rate-select pin chooses between a slow rate of 300 kHz and a fast rate of 500 kHz. When the sync pin carries nothing, or its edges are not usable, the block free-runs on this internal divider.

An external sync signal passes through a synchroniser, and the block times the interval between its rising edges in system clocks. The block switches over to that signal only when two things hold. The controller must report that startup has finished and the output is good. The sync signal must also have shown two consecutive intervals inside a ±15% window around the selected nominal period. Once it has switched, every cycle strobe follows a sync rising edge at a fixed latency. If the sync signal stops, drifts out of the window, or the startup-complete input drops, the block returns to the internal divider. It does this without issuing a cycle shorter than nominal and without issuing two strobes for one cycle.

Top module: `osc_sync_sel`

## Requirements
- R1: While reset is high and on the first clock after it, `cyc_start` and `src_ext` are both 0.
- R2: On the internal divider, consecutive `cyc_start` pulses are exactly N system clocks apart. N is round(CLK_HZ / 300 kHz) when `fsel_slow` is 1 and round(CLK_HZ / 500 kHz) when it is 0. At 50 MHz these give 167 and 100.
- R3: A sync interval of P clocks counts as in range only if floor(0.85·N) ≤ P ≤ floor(1.15·N). At 50 MHz this is 85..115 on the fast rate and 141..192 on the slow rate. A steady sync signal outside that window never moves the block off the internal divider.
- R4: While `ext_ok` is 0, `src_ext` stays 0 whatever the sync pin does. Dropping `ext_ok` while the block is external returns it to internal on the next clock.
- R5: The block adopts the sync signal only at a rising edge that closes the second consecutive in-range interval, which is the third edge of a fresh burst. Two edges alone leave `src_ext` at 0. Adoption raises `src_ext` and issues a `cyc_start` in the same clock.
- R6: While external, each `cyc_start` is a single-clock pulse. Counting the system edge that first sees the sync pin high as edge k, the pulse is high in the clock after edge k+3. Pulse spacing therefore equals the sync period.
- R7: While external, if no sync rising edge arrives within floor(1.15·N)+1 clocks of the last pulse, a pulse is issued at exactly that spacing and the block returns to internal. Later pulses are N apart.
- R8: Leaving the external source, whether through an out-of-range edge or `ext_ok` falling, never produces a pulse spacing below N or above floor(1.15·N)+1.
- R9: With the sync pin held low, the block free-runs on the internal divider and `src_ext` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fsel_slow | input | 1 | 1 selects the 300 kHz nominal rate, 0 selects 500 kHz |
| sync_in | input | 1 | Asynchronous external sync clock |
| ext_ok | input | 1 | Startup finished and output good; gates adoption of sync |
| cyc_start | output | 1 | One-clock strobe marking the start of each switching cycle |
| src_ext | output | 1 | 1 while cycles follow the external sync signal |

## Verification
The bench probes both edges of the acceptance window on both rates, one period inside and one outside each limit. A design with an off-by-one window would adopt 84 or 116 on the fast rate, or refuse 85 or 115. It feeds bursts of exactly two and exactly three sync edges to separate the consecutive-interval rule from premature adoption. It also measures the spacing of every strobe around a sync stall, an early edge and a startup-flag drop. These are the places where a careless handover emits a short or doubled cycle or stretches one beyond the timeout. Every external strobe is checked for its fixed four-clock lag behind the sync edge, which exposes missing or extra synchroniser stages.

// File: rtl/osc_sync_pkg.sv
package osc_sync_pkg;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;

  localparam int unsigned WIN_LO_PCT = 85;
  localparam int unsigned WIN_HI_PCT = 115;

  function automatic int unsigned div_round(input int unsigned num, input int unsigned den);
    return (num + den / 2) / den;
  endfunction

  function automatic int unsigned win_lo(input int unsigned nom);
    return (nom * WIN_LO_PCT) / 100;
  endfunction

  function automatic int unsigned win_hi(input int unsigned nom);
    return (nom * WIN_HI_PCT) / 100;
  endfunction

endpackage

// File: rtl/osc_rate_sel.sv
module osc_rate_sel #(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned SLOW_HZ = 300_000,
  parameter int unsigned FAST_HZ = 500_000,
  parameter int unsigned CW      = 16
) (
  input  logic          clk,
  input  logic          fsel_slow,
  output logic [CW-1:0] nom_o,
  output logic [CW-1:0] lo_o,
  output logic [CW-1:0] hi_o
);
  import osc_sync_pkg::*;

  localparam int unsigned NOM_S = div_round(CLK_HZ, SLOW_HZ);
  localparam int unsigned NOM_F = div_round(CLK_HZ, FAST_HZ);
  localparam logic [CW-1:0] NOM_S_V = CW'(NOM_S);
  localparam logic [CW-1:0] NOM_F_V = CW'(NOM_F);
  localparam logic [CW-1:0] LO_S_V  = CW'(win_lo(NOM_S));
  localparam logic [CW-1:0] LO_F_V  = CW'(win_lo(NOM_F));
  localparam logic [CW-1:0] HI_S_V  = CW'(win_hi(NOM_S));
  localparam logic [CW-1:0] HI_F_V  = CW'(win_hi(NOM_F));

  // Limits are registered so the pin feeds one flop, not the compare trees.
  always_ff @(posedge clk) begin
    nom_o <= fsel_slow ? NOM_S_V : NOM_F_V;
    lo_o  <= fsel_slow ? LO_S_V  : LO_F_V;
    hi_o  <= fsel_slow ? HI_S_V  : HI_F_V;
  end

endmodule

// File: rtl/osc_sync_edge.sv
module osc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] sh;

  // sh[STAGES-1] is the last synchroniser flop; sh[STAGES] is its delayed copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rise_o <= 1'b0;
    end else begin
      sh     <= {sh[STAGES-1:0], async_i};
      rise_o <= sh[STAGES-1] & ~sh[STAGES];
    end
  end

endmodule

// File: rtl/osc_period_meter.sv
module osc_period_meter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          period_ok_o,
  output logic          prior_ok_o
);

  logic [CW-1:0] span;

  // span holds clocks since the last edge; it parks above hi when stale.
  assign period_ok_o = (span >= lo_i) && (span <= hi_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      span       <= '1;
      prior_ok_o <= 1'b0;
    end else if (rise_i) begin
      span       <= CW'(1);
      prior_ok_o <= period_ok_o;
    end else begin
      if (span <= hi_i) span <= span + CW'(1);
      if (span > hi_i)  prior_ok_o <= 1'b0;
    end
  end

endmodule

// File: rtl/osc_sync_sel.sv
module osc_sync_sel #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned SLOW_HZ     = 300_000,
  parameter int unsigned FAST_HZ     = 500_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CW          = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fsel_slow,
  input  logic sync_in,
  input  logic ext_ok,
  output logic cyc_start,
  output logic src_ext
);
  import osc_sync_pkg::*;

  localparam int unsigned HI_SLOW = win_hi(div_round(CLK_HZ, SLOW_HZ));

  logic [CW-1:0] nom, lo, hi;
  logic          rise, period_ok, prior_ok;
  logic [CW-1:0] ph;
  src_e          mode, mode_nx;
  logic          fire;

  osc_rate_sel #(
    .CLK_HZ(CLK_HZ), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ), .CW(CW)
  ) u_rate (
    .clk(clk), .fsel_slow(fsel_slow), .nom_o(nom), .lo_o(lo), .hi_o(hi)
  );

  osc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_i(sync_in), .rise_o(rise)
  );

  osc_period_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst(rst), .rise_i(rise), .lo_i(lo), .hi_i(hi),
    .period_ok_o(period_ok), .prior_ok_o(prior_ok)
  );

  // ph counts clocks since the last issued cycle start in either mode.
  always_comb begin
    fire    = 1'b0;
    mode_nx = mode;
    unique case (mode)
      SRC_INT: begin
        if (ph >= nom - CW'(1)) fire = 1'b1;
        if (rise && ext_ok && period_ok && prior_ok) begin
          fire    = 1'b1;
          mode_nx = SRC_EXT;
        end
      end
      SRC_EXT: begin
        if (ph >= hi) begin
          fire    = 1'b1;
          mode_nx = SRC_INT;
        end else if (!ext_ok || (rise && !period_ok)) begin
          mode_nx = SRC_INT;
        end else if (rise) begin
          fire = 1'b1;
        end
      end
      default: mode_nx = SRC_INT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= SRC_INT;
      ph        <= '0;
      cyc_start <= 1'b0;
    end else begin
      mode      <= mode_nx;
      cyc_start <= fire;
      if (fire)            ph <= '0;
      else if (ph != '1)   ph <= ph + CW'(1);
    end
  end

  assign src_ext = (mode == SRC_EXT);

endmodule

// File: rtl/osc_sync_sel_chk.sv
module osc_sync_sel_chk (
  input logic        clk,
  input logic        rst,
  input logic        cyc_start,
  input logic        src_ext,
  input logic        ext_ok,
  input logic        rise,
  input logic [15:0] gap_lim
);

  logic [15:0] gap;

  always_ff @(posedge clk) begin
    if (rst || cyc_start) gap <= '0;
    else if (gap != '1)   gap <= gap + 16'd1;
  end

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  p_adopt_needs_ok_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(src_ext) |-> $past(ext_ok));

  p_adopt_fires_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(src_ext) |-> cyc_start);

  p_leave_on_ok_low_r8: assert property (@(posedge clk) disable iff (rst)
    (src_ext && !ext_ok) |=> !src_ext);

  p_ext_pulse_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && src_ext) |-> $past(rise));

  p_gap_bound_r7: assert property (@(posedge clk) disable iff (rst)
    gap <= gap_lim);

endmodule

bind osc_sync_sel osc_sync_sel_chk u_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .src_ext(src_ext),
  .ext_ok(ext_ok), .rise(rise), .gap_lim(16'(HI_SLOW + 1))
);

// File: tb/osc_sync_sel_test.sv
module osc_sync_sel_test;
  localparam int CLK_HZ = 50_000_000;

  logic clk = 1'b0, rst = 1'b1, fsel_slow = 1'b1, sync_in = 1'b0, ext_ok = 1'b0;
  logic cyc_start, src_ext;

  int checks = 0, errors = 0;
  int tick = 0, last_pulse = 0, last_iv = 0, npulse = 0, last_rise = -1000;
  int gen_per = 0, gen_left = 0, sph = 0, min_iv = 0, max_iv = 0;
  int req_per = 0, req_left = 0, req_n = 0, req_seen = 0, clr_n = 0, clr_seen = 0;
  bit done = 1'b0;

  osc_sync_sel #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .fsel_slow(fsel_slow), .sync_in(sync_in),
    .ext_ok(ext_ok), .cyc_start(cyc_start), .src_ext(src_ext)
  );

  initial forever #10 clk = ~clk;

  function automatic int nom_of(bit slow);
    int f = slow ? 300_000 : 500_000;
    return (CLK_HZ + f / 2) / f;
  endfunction

  function automatic bit accept(bit slow, int p);
    int n = nom_of(slow);
    return (p >= n * 85 / 100) && (p <= n * 115 / 100);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor and sync generator: the only writer of sync_in and pulse stats.
  initial forever begin
    @(negedge clk);
    tick++;
    if (req_seen != req_n) begin
      req_seen = req_n; gen_per = req_per; gen_left = req_left; sph = 0;
    end
    if (clr_seen != clr_n) begin
      clr_seen = clr_n; min_iv = 1_000_000; max_iv = 0;
    end
    if (!rst && cyc_start) begin
      last_iv = tick - last_pulse; last_pulse = tick; npulse++;
      if (last_iv < min_iv) min_iv = last_iv;
      if (last_iv > max_iv) max_iv = last_iv;
      if (src_ext) chk(tick - last_rise == 4, "R6 strobe lag", tick - last_rise, 4);
    end
    if (gen_per != 0 && gen_left != 0) begin
      sph++;
      if (sph >= gen_per) begin
        sph = 0; sync_in = 1'b1; last_rise = tick;
        if (gen_left > 0) gen_left--;
      end else if (sph == gen_per / 2) sync_in = 1'b0;
    end else sync_in = 1'b0;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_sync(int per, int left);
    req_per = per; req_left = left; req_n++;
  endtask

  task automatic clr_stats();
    clr_n++;
  endtask

  task automatic next_iv(output int iv);
    int n0 = npulse;
    while (npulse == n0) @(posedge clk);
    @(negedge clk);
    iv = last_iv;
  endtask

  task automatic try_period(bit slow, int p);
    int iv;
    bit exp;
    start_sync(0, 0);
    fsel_slow = slow;
    cyc(400);
    chk(src_ext == 1'b0, "R9 idle before trial", src_ext, 0);
    start_sync(p, -1);
    cyc(6 * p + 50);
    exp = accept(slow, p);
    chk(src_ext == exp, $sformatf("R3 window period %0d", p), src_ext, exp);
    if (exp) begin
      next_iv(iv);
      chk(iv == p, "R6 spacing follows sync", iv, p);
    end
  endtask

  initial begin
    int iv;
    int dp[8] = '{84, 85, 115, 116, 140, 141, 192, 193};
    bit ds[8] = '{0, 0, 0, 0, 1, 1, 1, 1};
    void'($urandom(32'd4242));
    cyc(5);
    chk(cyc_start == 1'b0 && src_ext == 1'b0, "R1 in reset", {cyc_start, src_ext}, 0);
    rst = 1'b0;
    last_pulse = tick;
    cyc(1);
    chk(cyc_start == 1'b0 && src_ext == 1'b0, "R1 after release", {cyc_start, src_ext}, 0);

    next_iv(iv);
    for (int i = 0; i < 3; i++) begin
      next_iv(iv);
      chk(iv == nom_of(1), "R2 slow rate", iv, nom_of(1));
    end
    fsel_slow = 1'b0;
    next_iv(iv); next_iv(iv);
    for (int i = 0; i < 3; i++) begin
      next_iv(iv);
      chk(iv == nom_of(0), "R2 fast rate", iv, nom_of(0));
    end
    chk(src_ext == 1'b0, "R9 sync low stays internal", src_ext, 0);

    start_sync(108, -1);
    cyc(1200);
    chk(src_ext == 1'b0, "R4 no adoption while not ok", src_ext, 0);
    next_iv(iv);
    chk(iv == 100, "R4 internal while not ok", iv, 100);

    ext_ok = 1'b1;
    cyc(500);
    chk(src_ext == 1'b1, "R5 adopts after ok", src_ext, 1);
    next_iv(iv); next_iv(iv);
    chk(iv == 108, "R6 external spacing", iv, 108);

    // Early edge while external.
    next_iv(iv);
    start_sync(70, -1);
    clr_stats();
    cyc(400);
    chk(src_ext == 1'b0, "R8 left on early edge", src_ext, 0);
    chk(min_iv >= 100, "R8 no short cycle", min_iv, 100);
    chk(max_iv <= 116, "R8 no stretched cycle", max_iv, 116);

    // ext_ok drop while external.
    start_sync(108, -1);
    cyc(600);
    chk(src_ext == 1'b1, "R5 readopted", src_ext, 1);
    clr_stats();
    cyc(37);
    ext_ok = 1'b0;
    cyc(2);
    chk(src_ext == 1'b0, "R4 leaves on ok low", src_ext, 0);
    cyc(400);
    chk(min_iv >= 100, "R8 ok drop no short cycle", min_iv, 100);
    chk(max_iv <= 116, "R8 ok drop no stretch", max_iv, 116);

    // Sync stall timeout.
    ext_ok = 1'b1;
    cyc(600);
    chk(src_ext == 1'b1, "R7 external before stall", src_ext, 1);
    next_iv(iv);
    start_sync(0, 0);
    clr_stats();
    cyc(400);
    chk(src_ext == 1'b0, "R7 back to internal", src_ext, 0);
    chk(max_iv == 116, "R7 timeout spacing", max_iv, 116);
    chk(min_iv == 100, "R7 nominal after timeout", min_iv, 100);

    // Two edges are not enough, three are.
    cyc(300);
    start_sync(100, 2);
    cyc(260);
    chk(src_ext == 1'b0, "R5 two edges no adoption", src_ext, 0);
    cyc(300);
    start_sync(100, 3);
    cyc(312);
    chk(src_ext == 1'b1, "R5 third edge adopts", src_ext, 1);

    for (int i = 0; i < 8; i++) try_period(ds[i], dp[i]);
    for (int i = 0; i < 8; i++) try_period(1'b0, 60 + int'($urandom % 81));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule